// File: doc/BRIEF.md
# Register-Mapped Serial Peripheral Master

This block is a single-lane SPI master that software drives through a small register bus. Software chooses one of eight active-low select lines and asserts it with an enable bit. It sets the clock divider, the frame length, the clock polarity and phase, and the shift direction of each path. A write to the transmit register then launches one frame of 8 or 16 bits. The frame's end sets a done flag. Software reads the received frame and clears the flag by writing zero to it.

The serial clock comes from two prescale stages. A 4-bit linear factor L (0 counts as 1) is multiplied by 2 raised to a 3-bit exponent E, which gives N = L·2^E. Each half of an SCLK period lasts N system cycles. MISO can be captured up to three system cycles after the nominal sampling edge, to absorb board delay. Every field of the configuration is copied when a frame starts, so a frame runs to its end with the settings it began with.

Top module: `spim_top`

## Requirements
- R1: After reset all chip-selects are high, SCLK and MOSI are low, and every register reads zero.
- R2: Control bit 0 enables selection and control bits 4:2 give a line number k. When enabled, only cs_n[k] is low. When disabled, all lines are high.
- R3: With config bits 3:0 = L and the exponent E = {config[7:6], config[4]}, each SCLK half-period lasts N = max(L,1)·2^E system cycles. The first edge comes N cycles after the launching write.
- R4: Config bit 5 selects a 16-bit frame when 1 and an 8-bit frame when 0. A frame has exactly 2·B SCLK edges, where B is the frame length.
- R5: Config bit 11 is the SCLK idle level, which SCLK follows whenever no frame runs. Config bit 12 = 0 presents data before the first edge and samples on leading edges. Config bit 12 = 1 launches data on leading edges and samples on trailing edges.
- R6: Config bit 13 = 1 shifts out LSB first and bit 14 = 1 shifts in LSB first. A value of 0 selects MSB first, and each path uses its own bit.
- R7: The done flag (offset 0x10, bit 0) rises at cycle max(2BN, S + D) + 1 after the launching write. S is the last sampling edge: 2BN when bit 12 = 1, (2B−1)N when bit 12 = 0. D is the sample delay. Offset 0x0C then holds the received frame, zero-extended.
- R8: Writing 0 to offset 0x10 clears the done flag, and writing a nonzero value leaves it unchanged. A frame end in the same cycle as a clearing write leaves the flag set.
- R9: Timing register (offset 0x18) bits 7:6 give D, the number of system cycles by which MISO capture trails each sampling edge.
- R10: Control bit 8 reads 1 while a frame runs. A write to the transmit register (offset 0x08) during a frame is ignored.
- R11: Changing the configuration or timing register during a frame has no effect on that frame. The new SCLK idle level applies once the frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |
| cs_n | output | 8 | Active-low chip-select lines |

## Verification
The end of a frame sets the done flag, and a software write of zero clears it. The two can land in the same cycle. The bench computes the exact completion cycle from the divider, the frame length and the sample delay. It then times a clearing write so that the write is sampled on that same edge, and it expects the flag to read 1 afterwards. A transmit write can also land on a running frame. The bench provokes this by writing a second data word mid-frame, and it judges the result by the bits its device model receives and by the unchanged completion cycle.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam int ADDR_W = 5;
    localparam int LIN_W  = 4;
    localparam int EXP_W  = 3;
    localparam int DLY_W  = 2;
    localparam int DIV_W  = LIN_W + (2 ** EXP_W) - 1;

    localparam logic [ADDR_W-1:0] OFF_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_CFG  = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_TXD  = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_RXD  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFF_DONE = 5'h10;
    localparam logic [ADDR_W-1:0] OFF_TMG  = 5'h18;

    typedef struct packed {
        logic             lsb_rx;
        logic             lsb_tx;
        logic             pha;
        logic             pol;
        logic             wide;
        logic [EXP_W-1:0] expo;
        logic [LIN_W-1:0] lin;
    } cfg_t;
endpackage

// File: rtl/spim_divsel.sv
module spim_divsel
    import spim_pkg::*;
(
    input  logic [LIN_W-1:0] lin_i,
    input  logic [EXP_W-1:0] expo_i,
    output logic [DIV_W-1:0] half_o
);
    logic [LIN_W-1:0] lin_eff;

    always_comb begin
        lin_eff = (lin_i == '0) ? LIN_W'(1) : lin_i;
        half_o  = DIV_W'(lin_eff) << expo_i;
    end
endmodule

// File: rtl/spim_csdec.sv
module spim_csdec #(
    parameter int CS_NUM = 8,
    localparam int SEL_W = $clog2(CS_NUM)
) (
    input  logic             en_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [CS_NUM-1:0] cs_n_o
);
    for (genvar g = 0; g < CS_NUM; g++) begin : g_line
        assign cs_n_o[g] = !(en_i && (sel_i == SEL_W'(g)));
    end
endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
#(
    parameter int FRAME_W  = 16,
    parameter int NARROW_W = 8,
    localparam int EDGE_W  = $clog2(2 * FRAME_W + 1),
    localparam int PEND_W  = (2 ** DLY_W) - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go_i,
    input  logic [FRAME_W-1:0] txd_i,
    input  cfg_t               cfg_i,
    input  logic [DIV_W-1:0]   half_i,
    input  logic [DLY_W-1:0]   dly_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [FRAME_W-1:0] rxd_o,
    output logic               sclk_o,
    output logic               mosi_o,
    input  logic               miso_i
);
    typedef struct packed {
        logic               busy;
        logic               sclk;
        logic [EDGE_W-1:0]  edges;
        logic [DIV_W-1:0]   div;
        logic [DIV_W-1:0]   per;
        cfg_t               cfg;
        logic [DLY_W-1:0]   dly;
        logic [PEND_W-1:0]  pend;
        logic [FRAME_W-1:0] tx;
        logic [FRAME_W-1:0] rx;
        logic [FRAME_W-1:0] rxd;
    } eng_t;

    eng_t st_d, st_q;
    int                 nb;
    logic [EDGE_W-1:0]  last_edge, nxt;
    logic [PEND_W:0]    chain;
    logic [PEND_W-1:0]  dmask;
    logic [FRAME_W-1:0] fmask;
    logic               tick, samp, shift, capture, pending, done;

    always_comb begin
        st_d      = st_q;
        nb        = st_q.cfg.wide ? FRAME_W : NARROW_W;
        last_edge = EDGE_W'(2 * nb);
        for (int i = 0; i < PEND_W; i++) dmask[i] = (i < int'(st_q.dly));
        for (int i = 0; i < FRAME_W; i++) fmask[i] = (i < nb);
        tick    = st_q.busy && (st_q.div == '0) && (st_q.edges != last_edge);
        nxt     = st_q.edges + 1'b1;
        samp    = tick && (nxt[0] ^ st_q.cfg.pha);
        shift   = tick && (st_q.cfg.pha ? (nxt[0] && nxt != EDGE_W'(1))
                                        : (!nxt[0] && nxt != last_edge));
        chain   = {st_q.pend, samp};
        capture = chain[st_q.dly];
        pending = |(st_q.pend & dmask);
        done    = st_q.busy && (st_q.edges == last_edge) && !pending;
        st_d.pend = {st_q.pend[PEND_W-2:0], samp};

        if (!st_q.busy) begin
            st_d.sclk = cfg_i.pol;
            if (go_i) begin
                st_d.busy  = 1'b1;
                st_d.cfg   = cfg_i;
                st_d.dly   = dly_i;
                st_d.per   = half_i;
                st_d.div   = half_i - 1'b1;
                st_d.edges = '0;
                st_d.tx    = txd_i;
                st_d.rx    = '0;
                st_d.pend  = '0;
            end
        end else begin
            if (st_q.div != '0) st_d.div = st_q.div - 1'b1;
            else if (tick)      st_d.div = st_q.per - 1'b1;
            if (tick) begin
                st_d.sclk  = ~st_q.sclk;
                st_d.edges = nxt;
            end
            if (shift) st_d.tx = st_q.cfg.lsb_tx ? (st_q.tx >> 1) : (st_q.tx << 1);
            if (capture) begin
                if (st_q.cfg.lsb_rx) begin
                    st_d.rx         = st_q.rx >> 1;
                    st_d.rx[nb - 1] = miso_i;
                end else begin
                    st_d.rx = {st_q.rx[FRAME_W-2:0], miso_i};
                end
            end
            if (done) begin
                st_d.busy = 1'b0;
                st_d.rxd  = st_q.rx & fmask;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign done_o = done;
    assign rxd_o  = st_q.rxd;
    assign sclk_o = st_q.sclk;
    assign mosi_o = st_q.busy && (st_q.cfg.lsb_tx ? st_q.tx[0] : st_q.tx[nb - 1]);

    a_r4_edge_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.edges <= last_edge);
    a_r3_div_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.div < st_q.per));
    a_r10_go_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && go_i && !done) |=> st_q.busy);
    a_r5_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && !go_i) |=> (sclk_o == $past(cfg_i.pol)));
endmodule

// File: rtl/spim_top.sv
module spim_top
    import spim_pkg::*;
#(
    parameter int BUS_W   = 16,
    parameter int CS_NUM  = 8,
    parameter int FRAME_W = 16,
    localparam int SEL_W  = $clog2(CS_NUM)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_en,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    output logic                sclk,
    output logic                mosi,
    input  logic                miso,
    output logic [CS_NUM-1:0]   cs_n
);
    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
        cfg_t             cfg;
        logic [DLY_W-1:0] dly;
        logic             cause;
    } reg_t;

    reg_t rg_d, rg_q;
    logic               wr, go, eng_busy, eng_done;
    logic [DIV_W-1:0]   half;
    logic [FRAME_W-1:0] rxd;

    always_comb begin
        rg_d = rg_q;
        wr   = bus_en && bus_we;
        go   = wr && (bus_addr == OFF_TXD);
        if (wr && bus_addr == OFF_CTRL) begin
            rg_d.en  = bus_wdata[0];
            rg_d.sel = bus_wdata[2 +: SEL_W];
        end
        if (wr && bus_addr == OFF_CFG) begin
            rg_d.cfg.lin    = bus_wdata[3:0];
            rg_d.cfg.expo   = {bus_wdata[7:6], bus_wdata[4]};
            rg_d.cfg.wide   = bus_wdata[5];
            rg_d.cfg.pol    = bus_wdata[11];
            rg_d.cfg.pha    = bus_wdata[12];
            rg_d.cfg.lsb_tx = bus_wdata[13];
            rg_d.cfg.lsb_rx = bus_wdata[14];
        end
        if (wr && bus_addr == OFF_TMG) rg_d.dly = bus_wdata[7:6];
        if (wr && bus_addr == OFF_DONE && bus_wdata == '0) rg_d.cause = 1'b0;
        if (eng_done) rg_d.cause = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_CTRL: begin
                bus_rdata[0]         = rg_q.en;
                bus_rdata[2 +: SEL_W] = rg_q.sel;
                bus_rdata[8]         = eng_busy;
            end
            OFF_CFG: begin
                bus_rdata[3:0] = rg_q.cfg.lin;
                bus_rdata[4]   = rg_q.cfg.expo[0];
                bus_rdata[5]   = rg_q.cfg.wide;
                bus_rdata[7:6] = rg_q.cfg.expo[2:1];
                bus_rdata[11]  = rg_q.cfg.pol;
                bus_rdata[12]  = rg_q.cfg.pha;
                bus_rdata[13]  = rg_q.cfg.lsb_tx;
                bus_rdata[14]  = rg_q.cfg.lsb_rx;
            end
            OFF_RXD:  bus_rdata[FRAME_W-1:0] = rxd;
            OFF_DONE: bus_rdata[0] = rg_q.cause;
            OFF_TMG:  bus_rdata[7:6] = rg_q.dly;
            default:  bus_rdata = '0;
        endcase
    end

    spim_divsel u_div (
        .lin_i  (rg_q.cfg.lin),
        .expo_i (rg_q.cfg.expo),
        .half_o (half)
    );

    spim_csdec #(.CS_NUM(CS_NUM)) u_cs (
        .en_i   (rg_q.en),
        .sel_i  (rg_q.sel),
        .cs_n_o (cs_n)
    );

    spim_engine #(.FRAME_W(FRAME_W)) u_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (go),
        .txd_i  (bus_wdata[FRAME_W-1:0]),
        .cfg_i  (rg_q.cfg),
        .half_i (half),
        .dly_i  (rg_q.dly),
        .busy_o (eng_busy),
        .done_o (eng_done),
        .rxd_o  (rxd),
        .sclk_o (sclk),
        .mosi_o (mosi),
        .miso_i (miso)
    );

    a_r2_cs_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
    a_r8_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> rg_q.cause);
    a_r2_cs_off: assert property (@(posedge clk) disable iff (!rst_n)
        !rg_q.en |-> (cs_n == '1));
endmodule

// File: tb/spim_top_test.sv
module spim_top_test;
    localparam int CLK_NS = 10;
    localparam int WD_CYC = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        sclk, mosi;
    logic        miso = 1'b0;
    logic [7:0]  cs_n;

    int checks = 0, errors = 0, cyc = 0;

    spim_top uut (.clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n));

    always #(CLK_NS / 2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WD_CYC) begin
            errors = errors + 1;
            $display("FAIL watchdog actual %0d expected below %0d", cyc, WD_CYC);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // device model: sends s_pat MSB first, collects MOSI MSB first
    logic        s_arm = 1'b0, s_pol = 1'b0, s_pha = 1'b0;
    int          s_nb = 8, s_out = 0, s_edges = 0;
    logic [15:0] s_pat = '0, s_rx = '0;

    always @(sclk) begin
        if (s_arm) begin
            s_edges = s_edges + 1;
            if ((sclk != s_pol) ^ s_pha) begin
                s_rx = {s_rx[14:0], mosi};
            end else if (s_out < s_nb) begin
                miso  = s_pat[s_nb - 1 - s_out];
                s_out = s_out + 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [15:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [15:0] rev(input logic [15:0] x, input int nb);
        logic [15:0] r = '0;
        for (int i = 0; i < nb; i++) r[i] = x[nb - 1 - i];
        return r;
    endfunction

    function automatic logic [15:0] cfgw(input logic [3:0] lin, input logic [2:0] ex,
        input logic wide, input logic pol, input logic pha, input logic ltx, input logic lrx);
        return {1'b0, lrx, ltx, pha, pol, 3'b000, ex[2:1], wide, ex[0], lin};
    endfunction

    // prepares and launches a frame; returns cycle of launch
    task automatic launch(input logic [3:0] lin, input logic [2:0] ex, input logic wide,
        input logic pol, input logic pha, input logic ltx, input logic lrx,
        input logic [1:0] dly, input logic [15:0] dat, input logic [15:0] pat, output int t0);
        logic [15:0] rd;
        bus_write(5'h18, {8'h00, dly, 6'h00});
        bus_write(5'h04, cfgw(lin, ex, wide, pol, pha, ltx, lrx));
        bus_write(5'h00, 16'h000D);
        check(sclk == pol, "R5 idle level", sclk, pol);
        s_pol = pol; s_pha = pha; s_nb = wide ? 16 : 8; s_pat = pat;
        s_rx = '0; s_edges = 0; s_out = 0;
        if (!pha) begin miso = pat[s_nb - 1]; s_out = 1; end
        s_arm = 1'b1;
        bus_write(5'h08, dat);
        t0 = cyc;
        bus_read(5'h00, rd);
        check(rd[8] == 1'b1, "R10 busy flag", rd[8], 1);
    endtask

    task automatic finish_frame(input string tag, input logic [3:0] lin, input logic [2:0] ex,
        input logic wide, input logic pha, input logic ltx, input logic lrx,
        input logic [1:0] dly, input logic [15:0] dat, input logic [15:0] pat, input int t0);
        logic [15:0] rd, m;
        int nb, n, ls, lat;
        nb = wide ? 16 : 8;
        m  = wide ? 16'hFFFF : 16'h00FF;
        n  = ((lin == 0) ? 1 : int'(lin)) << ex;
        ls = pha ? 2 * nb * n : (2 * nb - 1) * n;
        lat = ((ls + dly) > 2 * nb * n) ? (ls + dly + 1) : (2 * nb * n + 1);
        bus_read(5'h10, rd);
        while (rd[0] == 1'b0 && (cyc - t0) < 20000) begin
            @(negedge clk);
            bus_read(5'h10, rd);
        end
        s_arm = 1'b0;
        check(cyc - t0 == lat, {tag, " R7 completion cycle"}, cyc - t0, lat);
        bus_read(5'h0C, rd);
        check(rd == (lrx ? rev(pat, nb) : (pat & m)), {tag, " R6 received"}, rd,
              lrx ? rev(pat, nb) : (pat & m));
        check((s_rx & m) == (ltx ? rev(dat, nb) : (dat & m)), {tag, " R6 sent"}, s_rx & m,
              ltx ? rev(dat, nb) : (dat & m));
        check(s_edges == 2 * nb, {tag, " R4 edge count"}, s_edges, 2 * nb);
        bus_write(5'h10, 16'h0000);
    endtask

    task automatic frame(input string tag, input logic [3:0] lin, input logic [2:0] ex,
        input logic wide, input logic pol, input logic pha, input logic ltx, input logic lrx,
        input logic [1:0] dly, input logic [15:0] dat, input logic [15:0] pat);
        int t0;
        launch(lin, ex, wide, pol, pha, ltx, lrx, dly, dat, pat, t0);
        finish_frame(tag, lin, ex, wide, pha, ltx, lrx, dly, dat, pat, t0);
    endtask

    initial begin
        logic [15:0] rd;
        int t0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cs_n == 8'hFF, "R1 cs_n", cs_n, 8'hFF);
        check(sclk == 1'b0 && mosi == 1'b0, "R1 sclk/mosi", {sclk, mosi}, 0);
        foreach (rd[i]) begin end
        for (int a = 0; a < 32; a += 4) begin
            bus_read(5'(a), rd);
            check(rd == 16'h0, "R1 register reset", rd, 0);
        end

        // R2 select decode, every line
        for (int k = 0; k < 8; k++) begin
            bus_write(5'h00, 16'(k << 2) | 16'h1);
            check(cs_n == ~(8'h01 << k), "R2 select on", cs_n, ~(8'h01 << k));
            bus_write(5'h00, 16'(k << 2));
            check(cs_n == 8'hFF, "R2 select off", cs_n, 8'hFF);
        end

        // R4 R5 R6 sweep over every mode bit combination
        for (int c = 0; c < 32; c++) begin
            frame("R5 sweep", 4'd2, 3'd0, c[0], c[1], c[2], c[3], c[4], 2'd1,
                  16'hB4E1 ^ 16'(c * 37), 16'h5A3C ^ 16'(c * 91));
        end

        // R3 prescaler combinations including a zero linear factor
        frame("R3 lin0", 4'd0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 16'h00C3, 16'h0096);
        frame("R3 lin3", 4'd3, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0071, 16'h00E8);
        frame("R3 exp2", 4'd5, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0019, 16'h00A2);
        frame("R3 exp3", 4'd1, 3'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 16'h00F0, 16'h000F);
        frame("R3 exp5", 4'd15, 3'd5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0055, 16'h00AA);

        // R9 sample delay shifts completion
        for (int d = 0; d < 4; d++) begin
            frame("R9 delay", 4'd4, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'(d),
                  16'h0081 + 16'(d), 16'h00C5 - 16'(d));
        end

        // R10 R11: mid-frame transmit write and config change
        launch(4'd4, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 16'h003C, 16'h0069, t0);
        repeat (5) @(negedge clk);
        bus_write(5'h08, 16'h00A5);
        bus_read(5'h00, rd);
        check(rd[8] == 1'b1, "R10 busy mid-frame", rd[8], 1);
        bus_write(5'h04, cfgw(4'd1, 3'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1));
        bus_write(5'h18, 16'h00C0);
        finish_frame("R10 R11 hold", 4'd4, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0,
                     16'h003C, 16'h0069, t0);
        @(negedge clk);
        check(sclk == 1'b1, "R11 new idle level", sclk, 1);
        bus_read(5'h00, rd);
        check(rd[8] == 1'b0, "R10 busy clear", rd[8], 0);

        // R8 clear write on the completion cycle, and nonzero writes
        launch(4'd2, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0012, 16'h0034, t0);
        while (cyc < t0 + 2 * 8 * 2) @(negedge clk);
        bus_write(5'h10, 16'h0000);
        s_arm = 1'b0;
        bus_read(5'h10, rd);
        check(rd[0] == 1'b1, "R8 completion wins", rd[0], 1);
        bus_write(5'h10, 16'h0003);
        bus_read(5'h10, rd);
        check(rd[0] == 1'b1, "R8 nonzero keeps", rd[0], 1);
        bus_write(5'h10, 16'h0000);
        bus_read(5'h10, rd);
        check(rd[0] == 1'b0, "R8 zero clears", rd[0], 0);
        bus_write(5'h10, 16'h0001);
        bus_read(5'h10, rd);
        check(rd[0] == 1'b0, "R8 nonzero no set", rd[0], 0);
        bus_read(5'h0C, rd);
        check(rd == 16'h0034, "R7 data held", rd, 16'h0034);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule